// File: doc/BRIEF.md
# Stereo Over-Scale Hold Flags

This block watches the conversion results of a two-channel sampler and tells the surrounding logic when a channel has been driven into its limits. Each channel delivers a signed sample together with a one-cycle valid strobe. A sample counts as over scale when it equals either the most positive or the most negative code of the configured word length. When two over-scale results of the same channel arrive back to back, that channel's flag rises. The flag then stays up for a fixed number of frame-clock periods.

The hold window is timed by the frame clock and not by the system clock, and it does not depend on how many samples arrive. The frame clock is brought into the system clock domain by a synchronizer. Each of its rising edges, found by edge detection, advances the hold count by one. A fresh pair of over-scale results during the window starts the count again. An active-low power-down input forces both flags low at once. It also clears every piece of state, so both channels start clean when power-down is released.

Top module: `ovr_hold_flags`

## Requirements
- R1: After reset both flags are low.
- R2: A single over-scale result followed by an in-range result does not raise the flag.
- R3: Two consecutive valid results of one channel raise that channel's flag on the clock edge of the second strobe. Each result must equal +(2^(W-1)-1) or -(2^(W-1)) (for W=18: 131071 or -131072), in any mix.
- R4: An in-range valid result between two over-scale results clears the pair detector, so no flag rises.
- R5: The left and right channels are independent. Results on one channel never move the other channel's flag.
- R6: Once raised, a flag stays high through HOLD_PERIODS-1 synchronized frame-clock rising edges. It falls within three system-clock edges after rising edge number HOLD_PERIODS (default 4096). It never falls without a frame-clock edge.
- R7: A new over-scale pair during the hold window restarts the count, so the flag lasts HOLD_PERIODS edges from the new pair.
- R8: While pdn_n is low both flags read low in the same cycle. Releasing pdn_n leaves the flags low and the pair detectors empty.
- R9: Sample values presented while the valid strobe is low are ignored by the pair detector.
- R10: Codes one step inside full scale (2^(W-1)-2 and -(2^(W-1))+1) count as in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Digital power-down, active low |
| frame_clk | input | 1 | Frame clock, asynchronous to clk |
| left_sample | input | SAMPLE_W | Left conversion result, two's complement |
| left_valid | input | 1 | Left result strobe |
| right_sample | input | SAMPLE_W | Right conversion result, two's complement |
| right_valid | input | 1 | Right result strobe |
| left_flag | output | 1 | Left over-scale hold flag |
| right_flag | output | 1 | Right over-scale hold flag |

## Verification
Every cycle, the assertions check four things: a flag only rises directly after a detected over-scale pair; a raised flag only falls on a synchronized frame edge or under power-down; the hold count stays within its window; and both flags are low whenever power-down is asserted. The bench scenarios are the only way to show the rest. They show the exact length of the window in frame edges and its restart by a second pair. They show that an in-range result, an unstrobed sample, or a near-full-scale code breaks the pair. They also show that power-down empties the detector.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
   localparam int OVR_NUM_CH = 2;
   typedef enum int {OVR_LEFT = 0, OVR_RIGHT = 1} ovr_ch_e;

   function automatic int ovr_cnt_width(input int hold);
      return $clog2(hold + 1);
   endfunction
endpackage

// File: rtl/ovr_frame_edge.sv
module ovr_frame_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   input  logic frame_clk,
   output logic tick
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ovr_frame_edge: SYNC_STAGES must be at least 2");
   end

   localparam int CHAIN = SYNC_STAGES + 1;
   logic [CHAIN-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain_q <= '0;
      else if (!clr_n) chain_q <= '0;
      else             chain_q <= {chain_q[CHAIN-2:0], frame_clk};
   end

   assign tick = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R6
endmodule

// File: rtl/ovr_detect.sv
module ovr_detect #(
   parameter int SAMPLE_W = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_n,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                valid,
   output logic                pair_hit
);
   localparam logic [SAMPLE_W-1:0] POS_LIMIT = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic [SAMPLE_W-1:0] NEG_LIMIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic at_limit;
   logic armed_q;

   assign at_limit = (sample == POS_LIMIT) || (sample == NEG_LIMIT);
   assign pair_hit = clr_n & valid & at_limit & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q <= 1'b0;
      else if (!clr_n) armed_q <= 1'b0;
      else if (valid)  armed_q <= at_limit;
   end

   AST_ARM_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && clr_n) |=> (armed_q == $past(armed_q))); // R9
endmodule

// File: rtl/ovr_hold.sv
module ovr_hold #(
   parameter int HOLD_PERIODS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   input  logic start,
   input  logic tick,
   output logic flag
);
   if (HOLD_PERIODS < 2) begin : g_bad_hold
      $error("ovr_hold: HOLD_PERIODS must be at least 2");
   end

   localparam int CW = ovr_pkg::ovr_cnt_width(HOLD_PERIODS);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_PERIODS);

   logic [CW-1:0] left_q;
   logic          flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         flag_q <= 1'b0;
      end else if (!clr_n) begin
         left_q <= '0;
         flag_q <= 1'b0;
      end else if (start) begin
         left_q <= LOAD;
         flag_q <= 1'b1;
      end else if (tick && flag_q) begin
         if (left_q == CW'(1)) begin
            left_q <= '0;
            flag_q <= 1'b0;
         end else begin
            left_q <= left_q - CW'(1);
         end
      end
   end

   assign flag = flag_q;

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= LOAD); // R7
   AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !tick && clr_n) |=> flag_q); // R6
endmodule

// File: rtl/ovr_channel.sv
module ovr_channel #(
   parameter int SAMPLE_W     = 18,
   parameter int HOLD_PERIODS = 4096
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_n,
   input  logic                tick,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                valid,
   output logic                flag
);
   logic pair_hit;
   logic hold_flag;

   ovr_detect #(.SAMPLE_W(SAMPLE_W)) detect_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .sample(sample), .valid(valid), .pair_hit(pair_hit)
   );

   ovr_hold #(.HOLD_PERIODS(HOLD_PERIODS)) hold_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .start(pair_hit), .tick(tick), .flag(hold_flag)
   );

   assign flag = hold_flag & clr_n;

   AST_RISE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_flag) |-> $past(pair_hit)); // R3
endmodule

// File: rtl/ovr_hold_flags.sv
module ovr_hold_flags #(
   parameter int SAMPLE_W     = 18,
   parameter int HOLD_PERIODS = 4096,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pdn_n,
   input  logic                frame_clk,
   input  logic [SAMPLE_W-1:0] left_sample,
   input  logic                left_valid,
   input  logic [SAMPLE_W-1:0] right_sample,
   input  logic                right_valid,
   output logic                left_flag,
   output logic                right_flag
);
   import ovr_pkg::*;

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("ovr_hold_flags: SAMPLE_W must be at least 2");
   end

   logic                tick;
   logic [SAMPLE_W-1:0] ch_sample [OVR_NUM_CH];
   logic                ch_valid  [OVR_NUM_CH];
   logic                ch_flag   [OVR_NUM_CH];

   assign ch_sample[OVR_LEFT]  = left_sample;
   assign ch_sample[OVR_RIGHT] = right_sample;
   assign ch_valid[OVR_LEFT]   = left_valid;
   assign ch_valid[OVR_RIGHT]  = right_valid;

   ovr_frame_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk(clk), .rst_n(rst_n), .clr_n(pdn_n),
      .frame_clk(frame_clk), .tick(tick)
   );

   for (genvar c = 0; c < OVR_NUM_CH; c++) begin : g_ch
      ovr_channel #(.SAMPLE_W(SAMPLE_W), .HOLD_PERIODS(HOLD_PERIODS)) chan_i (
         .clk(clk), .rst_n(rst_n), .clr_n(pdn_n), .tick(tick),
         .sample(ch_sample[c]), .valid(ch_valid[c]), .flag(ch_flag[c])
      );
   end

   assign left_flag  = ch_flag[OVR_LEFT];
   assign right_flag = ch_flag[OVR_RIGHT];

   AST_PDN_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_n |-> (!left_flag && !right_flag)); // R8
endmodule

// File: tb/ovr_hold_flags_tb_top.sv
module ovr_hold_flags_tb_top;
   localparam int  W      = 18;
   localparam int  HOLD   = 4096;
   localparam time CLK_T  = 10ns;
   localparam logic [W-1:0] PMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NMIN = {1'b1, {(W-1){1'b0}}};

   logic clk = 1'b0, rst_n = 1'b0, pdn_n = 1'b1, frame_clk = 1'b0;
   logic [W-1:0] l_s = '0, r_s = '0;
   logic l_v = 1'b0, r_v = 1'b0;
   logic l_f, r_f;
   logic fr_en = 1'b0;
   int   fr_div = 0;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #(CLK_T/2) clk = ~clk;

   always @(negedge clk) begin
      if (!fr_en) begin
         frame_clk <= 1'b0;
         fr_div    <= 0;
      end else if (fr_div == 2) begin
         frame_clk <= ~frame_clk;
         fr_div    <= 0;
      end else begin
         fr_div <= fr_div + 1;
      end
   end

   ovr_hold_flags #(.SAMPLE_W(W), .HOLD_PERIODS(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .frame_clk(frame_clk),
      .left_sample(l_s), .left_valid(l_v),
      .right_sample(r_s), .right_valid(r_v),
      .left_flag(l_f), .right_flag(r_f)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic send(input bit right, input logic [W-1:0] v);
      @(negedge clk);
      if (right) begin r_s = v; r_v = 1'b1; end
      else       begin l_s = v; l_v = 1'b1; end
      @(negedge clk);
      r_v = 1'b0; l_v = 1'b0;
   endtask

   task automatic frames(input int n);
      fr_en = 1'b1;
      repeat (n) @(posedge frame_clk);
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic stop_frames();
      @(negedge clk);
      fr_en = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_all();
      @(negedge clk);
      pdn_n = 1'b0;
      repeat (2) @(negedge clk);
      pdn_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 left after reset", l_f, 1'b0);
      check("R1 right after reset", r_f, 1'b0);
   endtask

   task automatic t_single();
      send(0, PMAX); send(0, 18'd5); send(0, PMAX);
      check("R2 single then in-range", l_f, 1'b0);
      clear_all();
   endtask

   task automatic t_broken_pair();
      send(1, NMIN); send(1, '0); send(1, NMIN);
      check("R4 in-range breaks pair", r_f, 1'b0);
      clear_all();
   endtask

   task automatic t_no_valid();
      @(negedge clk);
      l_s = PMAX;
      repeat (5) @(negedge clk);
      send(0, PMAX);
      check("R9 unstrobed samples ignored", l_f, 1'b0);
      clear_all();
   endtask

   task automatic t_near_scale();
      send(0, PMAX - 1); send(0, PMAX - 1);
      check("R10 max-1 in range", l_f, 1'b0);
      send(1, NMIN + 1); send(1, NMIN + 1);
      check("R10 min+1 in range", r_f, 1'b0);
      clear_all();
   endtask

   task automatic t_pairs();
      send(0, PMAX); send(0, NMIN);
      check("R3 mixed pair raises left", l_f, 1'b1);
      check("R5 right untouched by left", r_f, 1'b0);
      send(1, NMIN); send(1, NMIN);
      check("R3 negative pair raises right", r_f, 1'b1);
      check("R5 left unchanged by right", l_f, 1'b1);
      clear_all();
   endtask

   task automatic t_hold();
      send(0, PMAX); send(0, PMAX);
      check("R3 positive pair raises left", l_f, 1'b1);
      repeat (20) @(negedge clk);
      check("R6 no fall without frame edges", l_f, 1'b1);
      frames(HOLD - 1);
      check("R6 high after HOLD-1 edges", l_f, 1'b1);
      frames(1);
      check("R6 low after HOLD edges", l_f, 1'b0);
      stop_frames();
   endtask

   task automatic t_retrigger();
      send(1, PMAX); send(1, PMAX);
      frames(2000);
      stop_frames();
      check("R7 still high mid window", r_f, 1'b1);
      send(1, NMIN); send(1, PMAX);
      frames(HOLD - 1);
      check("R7 restarted window still high", r_f, 1'b1);
      frames(1);
      check("R7 restarted window ends", r_f, 1'b0);
      stop_frames();
   endtask

   task automatic t_powerdown();
      send(0, PMAX); send(0, PMAX);
      check("R8 setup flag high", l_f, 1'b1);
      @(negedge clk);
      pdn_n = 1'b0;
      #1;
      check("R8 flag low during power-down", l_f, 1'b0);
      repeat (2) @(negedge clk);
      pdn_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 flag low after release", l_f, 1'b0);
      send(0, PMAX);
      @(negedge clk);
      pdn_n = 1'b0;
      repeat (2) @(negedge clk);
      pdn_n = 1'b1;
      send(0, PMAX);
      check("R8 detector emptied by power-down", l_f, 1'b0);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_broken_pair();
      t_no_valid();
      t_near_scale();
      t_pairs();
      t_hold();
      t_retrigger();
      t_powerdown();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule